// File: doc/BRIEF.md
# Shared-Line Serial Game Pad Poller

The block reads up to four serial game pads at once. All pads share one latch line and one clock line, and each pad has its own data line. A start request in the idle state begins a poll. The poller pulses the shared latch to snapshot every pad's buttons. It then produces clock pulses until each pad has shifted out either a short 8-bit word (basic pads) or a long 16-bit word (extended pads, two 8-bit halves back to back). Every data line is sampled in the same cycle, so all ports are captured in parallel.

Each shared-line phase lasts a programmable number of system cycles, which sets the pad clock rate. When the last bit is in, the block updates one button word per port and raises a single-cycle completion pulse. Each button word is inverted so that a pressed button reads 1. The words then hold until the next poll completes, so software can read them at any time.

Top module: `pad_poller`

## Requirements
- R1: After synchronous reset, `pad_latch_o`, `pad_clk_o`, `busy_o` and `done_o` are low and every button word is zero.
- R2: A start accepted in idle sets `busy_o` and drives `pad_latch_o` high for exactly T = `phase_div_i`+1 cycles. A gap of T cycles with latch and clock both low follows.
- R3: `pad_latch_o` and `pad_clk_o` are never high in the same cycle, and both stay low while the block is idle.
- R4: With `long_mode_i` = 0 the poll reads 8 bits using 7 clock pulses, each high for T cycles and then low for T cycles. Bits 15:8 of every word read 0.
- R5: With `long_mode_i` = 1 the poll reads 16 bits using 15 clock pulses with the same T-high, T-low shape.
- R6: The bit sampled at the end of the gap goes to bit 0 of the word. The bit sampled at the end of the low half that follows clock pulse k goes to bit k.
- R7: Data lines are active low: a sampled 0 is stored as 1 and a sampled 1 is stored as 0.
- R8: All ports are sampled in the same cycle. Port p's word appears on `buttons_o[16*p +: 16]`.
- R9: `done_o` is high for exactly one cycle, in the same cycle that the new words appear. That cycle begins 2·N·T cycles after the accepting edge, where N is the word length.
- R10: Button words change only in a cycle where `done_o` is high.
- R11: `busy_o` stays high from the accepting edge until the done cycle. A start request seen while busy has no effect.
- R12: In the done cycle `busy_o` is already low, so a start request present in that cycle is accepted and a new poll follows at once.
- R13: `long_mode_i` and `phase_div_i` are captured when a start is accepted. Changing them during a poll does not alter that poll's timing or word length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Poll request, acted on only when idle |
| long_mode_i | input | 1 | 0: 8-bit words, 1: 16-bit words |
| phase_div_i | input | 8 | Phase length minus one, in system cycles |
| pad_data_n_i | input | 4 | Active-low serial data, one line per port |
| pad_latch_o | output | 1 | Shared latch line |
| pad_clk_o | output | 1 | Shared clock line |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| buttons_o | output | 64 | Four 16-bit button words, pressed = 1 |

## Verification
The completion pulse and the acceptance of a new start can happen in the same cycle. The bench provokes this by holding `start_i` high across a whole poll. The bench judges the result from timing: the second completion must come exactly 2·N·T+1 cycles after the first accepting edge plus 2·N·T. The bench also changes the pad model's buttons in the done cycle, so that the second word set must differ from the first. If the design ignored the overlapping request or started a poll early, the completion cycle, the latch count or the captured words would be off.

// File: rtl/pad_poll_pkg.sv
package pad_poll_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LATCH,
        PH_GAP,
        PH_CLK_HI,
        PH_CLK_LO
    } phase_e;

    typedef struct packed {
        logic latch;
        logic clk;
    } pad_drive_t;

    // Shared-line levels for each phase of the poll.
    function automatic pad_drive_t drive_of(phase_e ph);
        pad_drive_t d;
        d = '0;
        case (ph)
            PH_LATCH:  d.latch = 1'b1;
            PH_CLK_HI: d.clk   = 1'b1;
            default:   d       = '0;
        endcase
        return d;
    endfunction

    // A sampling instant ends the gap or a clock-low half.
    function automatic logic is_sample_phase(phase_e ph);
        return (ph == PH_GAP) || (ph == PH_CLK_LO);
    endfunction

endpackage

// File: rtl/pp_tick_gen.sv
module pp_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == limit_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assert_tick_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q <= limit_i))
        else $error("phase counter passed its limit");

endmodule

// File: rtl/pp_sequencer.sv
module pp_sequencer
    import pad_poll_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 16,
    localparam int IDX_W  = $clog2(LONG_W),
    localparam int LEN_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             long_mode_i,
    input  logic [DIV_W-1:0] phase_div_i,
    input  logic             tick_i,
    output logic [DIV_W-1:0] div_o,
    output logic             run_o,
    output logic             clear_o,
    output logic             sample_o,
    output logic             last_o,
    output logic [IDX_W-1:0] bit_idx_o,
    output logic             pad_latch_o,
    output logic             pad_clk_o,
    output logic             busy_o,
    output logic             done_o
);
    phase_e           phase_q, phase_d;
    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic             accept;
    pad_drive_t       drv;

    assign accept    = (phase_q == PH_IDLE) && start_i;
    assign run_o     = (phase_q != PH_IDLE);
    assign busy_o    = run_o;
    assign clear_o   = accept;
    assign div_o     = div_q;
    assign bit_idx_o = idx_q;
    assign sample_o  = tick_i && is_sample_phase(phase_q);
    assign last_o    = ({1'b0, idx_q} == (len_q - LEN_W'(1)));
    assign done_o    = done_q;

    assign drv         = drive_of(phase_q);
    assign pad_latch_o = drv.latch;
    assign pad_clk_o   = drv.clk;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:   if (start_i) phase_d = PH_LATCH;
            PH_LATCH:  if (tick_i)  phase_d = PH_GAP;
            PH_GAP:    if (tick_i)  phase_d = PH_CLK_HI;
            PH_CLK_HI: if (tick_i)  phase_d = PH_CLK_LO;
            PH_CLK_LO: if (tick_i)  phase_d = last_o ? PH_IDLE : PH_CLK_HI;
            default:                phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            div_q   <= '0;
            len_q   <= LEN_W'(SHORT_W);
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= sample_o && last_o;
            if (accept) begin
                div_q <= phase_div_i;
                len_q <= long_mode_i ? LEN_W'(LONG_W) : LEN_W'(SHORT_W);
                idx_q <= '0;
            end else if (sample_o && !last_o) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assert_lines_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(pad_latch_o && pad_clk_o))
        else $error("latch and clock high together");

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!pad_latch_o && !pad_clk_o))
        else $error("shared lines active while idle");

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o)
        else $error("done held longer than one cycle");

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(div_q) && $stable(len_q)))
        else $error("start while busy altered the poll");

    assert_index_in_word_R4: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> ({1'b0, idx_q} < len_q))
        else $error("sample index beyond word length");

endmodule

// File: rtl/pp_port_capture.sv
module pp_port_capture #(
    parameter int LONG_W = 16,
    localparam int IDX_W = $clog2(LONG_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              last_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic              data_n_i,
    output logic [LONG_W-1:0] word_o
);
    logic [LONG_W-1:0] shadow_q;
    logic [LONG_W-1:0] shadow_d;
    logic [LONG_W-1:0] word_q;

    always_comb begin
        shadow_d            = shadow_q;
        shadow_d[bit_idx_i] = ~data_n_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            word_q   <= '0;
        end else begin
            if (clear_i) begin
                shadow_q <= '0;
            end else if (sample_i) begin
                shadow_q <= shadow_d;
                if (last_i) begin
                    word_q <= shadow_d;
                end
            end
        end
    end

    assign word_o = word_q;

    assert_word_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_o) |-> $past(sample_i && last_i))
        else $error("button word changed outside completion");

endmodule

// File: rtl/pad_poller.sv
module pad_poller #(
    parameter int N_PORTS = 4,
    parameter int DIV_W   = 8,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 16,
    localparam int IDX_W  = $clog2(LONG_W)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      long_mode_i,
    input  logic [DIV_W-1:0]          phase_div_i,
    input  logic [N_PORTS-1:0]        pad_data_n_i,
    output logic                      pad_latch_o,
    output logic                      pad_clk_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [N_PORTS*LONG_W-1:0] buttons_o
);
    logic             tick;
    logic             run;
    logic             clear;
    logic             sample;
    logic             last;
    logic [DIV_W-1:0] div_q;
    logic [IDX_W-1:0] bit_idx;

    pp_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .limit_i (div_q),
        .tick_o  (tick)
    );

    pp_sequencer #(
        .DIV_W   (DIV_W),
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .long_mode_i (long_mode_i),
        .phase_div_i (phase_div_i),
        .tick_i      (tick),
        .div_o       (div_q),
        .run_o       (run),
        .clear_o     (clear),
        .sample_o    (sample),
        .last_o      (last),
        .bit_idx_o   (bit_idx),
        .pad_latch_o (pad_latch_o),
        .pad_clk_o   (pad_clk_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        pp_port_capture #(.LONG_W(LONG_W)) cap_i (
            .clk       (clk),
            .rst       (rst),
            .clear_i   (clear),
            .sample_i  (sample),
            .last_i    (last),
            .bit_idx_i (bit_idx),
            .data_n_i  (pad_data_n_i[p]),
            .word_o    (buttons_o[p*LONG_W +: LONG_W])
        );
    end

endmodule

// File: tb/pad_poller_tb.sv
module pad_poller_tb_top;
    localparam int NP = 4;
    localparam int WW = 16;

    typedef struct packed {
        logic [NP-1:0][WW-1:0] words;
        int                    nbits;
        int                    tph;
        longint                done_cyc;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              long_mode_i = 1'b0;
    logic [7:0]        phase_div_i = '0;
    logic [NP-1:0]     pad_data_n_i;
    logic              pad_latch_o, pad_clk_o, busy_o, done_o;
    logic [NP*WW-1:0]  buttons_o;

    pad_poller dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .long_mode_i(long_mode_i),
        .phase_div_i(phase_div_i), .pad_data_n_i(pad_data_n_i),
        .pad_latch_o(pad_latch_o), .pad_clk_o(pad_clk_o), .busy_o(busy_o),
        .done_o(done_o), .buttons_o(buttons_o)
    );

    always #5 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Pad model: pressed = 1 in pad_btn, active-low serial output.
    logic [NP-1:0][WW-1:0] pad_btn = '0;
    logic [NP-1:0][WW-1:0] pad_sh  = '0;
    always @(posedge pad_latch_o) pad_sh <= pad_btn;
    always @(posedge pad_clk_o) begin
        for (int p = 0; p < NP; p++) pad_sh[p] <= pad_sh[p] >> 1;
    end
    always_comb begin
        for (int p = 0; p < NP; p++) pad_data_n_i[p] = ~pad_sh[p][0];
    end

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Monitor / scoreboard
    int lat_cnt = 0, pulses = 0, hi_cnt = 0;
    logic lat_prev = 1'b0, clk_prev = 1'b0;
    logic [NP*WW-1:0] last_btn = '0;
    int stab_err = 0, excl_err = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (pad_latch_o && !lat_prev) begin
                lat_cnt = 0; pulses = 0; hi_cnt = 0;
            end
            if (pad_latch_o) lat_cnt++;
            if (pad_clk_o && !clk_prev) pulses++;
            if (pad_clk_o) hi_cnt++;
            if (pad_latch_o && pad_clk_o) excl_err++;
            if (!busy_o && (pad_latch_o || pad_clk_o)) excl_err++;
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    for (int p = 0; p < NP; p++)
                        check(buttons_o[p*WW +: WW] == e.words[p], "R6/R7/R8",
                              $sformatf("port %0d word", p),
                              buttons_o[p*WW +: WW], e.words[p]);
                    check(cyc == e.done_cyc, "R9", "done cycle", cyc, e.done_cyc);
                    check(busy_o == 1'b0, "R12", "busy in done cycle", busy_o, 0);
                    check(lat_cnt == e.tph, "R2", "latch width", lat_cnt, e.tph);
                    check(pulses == e.nbits - 1, e.nbits == 16 ? "R5" : "R4",
                          "clock pulses", pulses, e.nbits - 1);
                    check(hi_cnt == (e.nbits - 1) * e.tph, "R4", "clock high cycles",
                          hi_cnt, (e.nbits - 1) * e.tph);
                end
                last_btn = buttons_o;
            end else if (buttons_o != last_btn) begin
                stab_err++;
                last_btn = buttons_o;
            end
        end
        lat_prev = pad_latch_o;
        clk_prev = pad_clk_o;
    end

    function automatic exp_t mk_exp(input logic [NP-1:0][WW-1:0] b, input bit lng,
                                    input int div, input longint c0);
        exp_t e;
        for (int p = 0; p < NP; p++) e.words[p] = lng ? b[p] : (b[p] & 16'h00FF);
        e.nbits    = lng ? 16 : 8;
        e.tph      = div + 1;
        e.done_cyc = c0 + 2 * e.nbits * e.tph;
        return e;
    endfunction

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Driver: push the expected item and pulse start.
    task automatic poll(input logic [NP-1:0][WW-1:0] b, input bit lng, input int div,
                        input bit disturb);
        longint c0;
        pad_btn = b;
        @(negedge clk);
        long_mode_i = lng;
        phase_div_i = 8'(div);
        start_i     = 1'b1;
        @(posedge clk);
        #1 c0 = cyc;
        exp_q.push_back(mk_exp(b, lng, div, c0));
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            // R13: changed settings mid-poll; R11: start while busy
            repeat (3) @(negedge clk);
            long_mode_i = ~lng;
            phase_div_i = 8'(div + 3);
            start_i     = 1'b1;
            @(negedge clk);
            start_i     = 1'b0;
        end
        wait_empty();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "run timed out", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [NP-1:0][WW-1:0] b1, b2;
        longint c0;
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!pad_latch_o && !pad_clk_o && !busy_o && !done_o, "R1", "idle outputs",
              {pad_latch_o, pad_clk_o, busy_o, done_o}, 0);
        check(buttons_o == '0, "R1", "reset words", buttons_o[31:0], 0);

        b1 = {16'h8001, 16'h00FF, 16'h5A3C, 16'h00A5};
        poll(b1, 1'b0, 1, 1'b0);                     // R4 short words
        b1 = {16'hA5C3, 16'h0F0F, 16'h8421, 16'hFFFE};
        poll(b1, 1'b1, 3, 1'b0);                     // R5 long words
        b1 = {16'hFFFF, 16'h0000, 16'h0001, 16'h8000};
        poll(b1, 1'b1, 0, 1'b0);                     // R6 edge bits, minimum divider
        b1 = {16'h1234, 16'hFEDC, 16'h0000, 16'hFFFF};
        poll(b1, 1'b0, 2, 1'b1);                     // R11 and R13 disturbance

        // R12: start held across a poll, accepted again in the done cycle
        b1 = {16'h0101, 16'h0202, 16'h0404, 16'h0808};
        b2 = {16'hF0F0, 16'h0F0F, 16'hCCCC, 16'h3333};
        pad_btn = b1;
        @(negedge clk);
        long_mode_i = 1'b1;
        phase_div_i = 8'd1;
        start_i     = 1'b1;
        @(posedge clk);
        #1 c0 = cyc;
        k = 2 * 16 * 2;
        exp_q.push_back(mk_exp(b1, 1'b1, 1, c0));
        exp_q.push_back(mk_exp(b2, 1'b1, 1, c0 + k + 1));
        while (cyc != c0 + k) @(negedge clk);
        pad_btn = b2;
        @(negedge clk);
        start_i = 1'b0;
        wait_empty();

        check(exp_q.size() == 0, "R11", "outstanding items", exp_q.size(), 0);
        check(stab_err == 0, "R10", "word changes outside done", stab_err, 0);
        check(excl_err == 0, "R3", "line overlap or idle activity", excl_err, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule